// File: doc/BRIEF.md
# Stereo I2S Bus Master Port

This block drives a stereo I2S link as the clock master. It divides the master clock down to a bit clock and generates the word-select line. It shifts 32-bit left and right samples out to a DAC and assembles the serial ADC data into stereo pairs. Each frame has 64 bit clocks, with 32 bits per channel slot. The divide ratio is the master clock divided by (fs × 64), and it must be 1, 2, 4, 8 or 16.

The divider is counted in core-clock cycles. The core clock runs at twice the master-clock rate, so ratio code k gives a bit-clock half period of 2^k core cycles, and divide-by-one is possible with registered outputs only. The system picks the master-clock family beforehand. It uses the 44.1 kHz family clock when that clock is an exact multiple of fs and the 48 kHz family otherwise, and it passes the resulting ratio code to this block.

Upstream logic supplies one stereo frame per word-select period. The block pulses `frame_take` and captures `tx_left`/`tx_right` at the end of that cycle. If `tx_underflow` is high at capture, the block sends zero words instead. A start request launches streaming with the ratio code then present. A stop request parks both clocks low so the port can be reconfigured.

Top module: `i2s_master_port`

## Requirements
- R1: While streaming, `bclk` holds each level for exactly 2^`ratio_code` core cycles. A 64-bit frame therefore lasts 128·2^`ratio_code` cycles.
- R2: A start request with `ratio_code` greater than 4 is refused. `cfg_err` rises in the next cycle and stays high until a valid start, and `active`, `bclk`, `lrclk` and `sdout` stay low.
- R3: `lrclk` is low for the left slot (bits 0–31) and high for the right slot (bits 32–63). It toggles on the falling `bclk` edge that begins bit 31 or bit 63, one bit ahead of each slot's MSB.
- R4: `sdout` changes only on falling `bclk` edges. It carries the left word and then the right word, MSB first, and bit 0 of a frame is the left MSB.
- R5: After an accepted start, `active` and `bclk` are high in the next cycle. `lrclk` is high and `sdout` is 0. `bclk` stays high for one half period, and then the last bit of a lead-in frame carrying zero data follows.
- R6: A stop request while `active` drives `bclk`, `lrclk` and `sdout` low and clears `active` in the next cycle. After reset the block is idle with all of these low.
- R7: `frame_take` is a single-cycle pulse in the first cycle of bit 63 of every frame. `tx_left`, `tx_right` and `tx_underflow` are captured at the end of that cycle and supply the next frame.
- R8: A frame captured while `tx_underflow` is high sends all-zero words on both channels. This holds for every frame captured while the flag stays high.
- R9: `sdin` is sampled on rising `bclk` edges, MSB first. One cycle after the rising edge of bit 63, `rx_valid` pulses for one cycle with the left word of bits 0–31 and the right word of bits 32–63 of the same frame. The incomplete lead-in frame produces no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Begin streaming when idle |
| stop_req | input | 1 | Park clocks low and stop when active |
| ratio_code | input | 3 | log2 of the divide ratio, valid 0..4 |
| cfg_err | output | 1 | Last start was refused for a bad ratio |
| active | output | 1 | Port is streaming |
| tx_left | input | 32 | Left DAC sample |
| tx_right | input | 32 | Right DAC sample |
| tx_underflow | input | 1 | Source has no data; send zeros |
| frame_take | output | 1 | Sample words captured at end of this cycle |
| rx_valid | output | 1 | ADC pair valid pulse |
| rx_left | output | 32 | Received left word |
| rx_right | output | 32 | Received right word |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word select, low = left |
| sdout | output | 1 | Serial DAC data |
| sdin | input | 1 | Serial ADC data |

## Verification
A wrong divide count or phase shows up within one half period as a `bclk` level that lasts too long or too short. It also shifts every later `lrclk` and `frame_take` position, so the per-cycle comparison fails within a few core cycles. A corrupt shift register or bit index puts a wrong `sdout` bit in the first frame after the fault. Bad receive pairing is seen at the next `rx_valid` pulse as a wrong word, or as a pulse in the wrong cycle. The bench therefore runs every ratio, underflow spanning two frames, refused ratios and a restart, and it compares every output on every cycle.

// File: rtl/i2sm_pkg.sv
package i2sm_pkg;

  // Width of one channel slot; a frame holds a left and a right slot.
  localparam int SLOT_W     = 32;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic [SLOT_W-1:0] left;
    logic [SLOT_W-1:0] right;
  } stereo_word_t;

  // Word-select level for a bit position: high from the bit before the
  // right MSB up to the bit before the left MSB.
  function automatic logic ws_level(input logic [BIT_W-1:0] b);
    return (b >= BIT_W'(SLOT_W - 1)) && (b <= BIT_W'(FRAME_BITS - 2));
  endfunction

endpackage

// File: rtl/i2sm_clkgen.sv
module i2sm_clkgen
  import i2sm_pkg::*;
#(
  parameter int RATIO_LOG2_MAX = 4,
  parameter int CODE_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [CODE_W-1:0] ratio_code,
  output logic             active,
  output logic             cfg_err,
  output logic             bclk,
  output logic             lrclk,
  output logic [BIT_W-1:0] bit_idx,
  output logic [BIT_W-1:0] next_bit,
  output logic             start_stb,
  output logic             stop_stb,
  output logic             fall_stb,
  output logic             rise_stb
);

  localparam int DIV_W = RATIO_LOG2_MAX + 1;

  logic             run_q,  run_d;
  logic             half_q, half_d;
  logic [DIV_W-1:0] div_q,  div_d;
  logic [DIV_W-1:0] lim_q,  lim_d;
  logic [BIT_W-1:0] bit_q,  bit_d;
  logic             lr_q,   lr_d;
  logic             err_q,  err_d;
  logic             code_ok;
  logic             div_hit;

  assign code_ok   = (ratio_code <= CODE_W'(RATIO_LOG2_MAX));
  assign start_stb = !run_q && start_req && code_ok;
  assign stop_stb  = run_q && stop_req;
  assign div_hit   = (div_q == lim_q);
  assign fall_stb  = run_q && !stop_req && div_hit && half_q;
  assign rise_stb  = run_q && !stop_req && div_hit && !half_q;
  assign next_bit  = bit_q + BIT_W'(1);

  // Next-state logic
  always_comb begin
    run_d  = run_q;
    half_d = half_q;
    div_d  = div_q;
    lim_d  = lim_q;
    bit_d  = bit_q;
    lr_d   = lr_q;
    err_d  = err_q;
    if (start_stb) begin
      run_d  = 1'b1;
      half_d = 1'b1;
      div_d  = '0;
      lim_d  = DIV_W'((32'd1 << ratio_code) - 32'd1);
      bit_d  = BIT_W'(FRAME_BITS - 2);
      lr_d   = 1'b1;
      err_d  = 1'b0;
    end else if (!run_q && start_req) begin
      err_d  = 1'b1;
    end else if (stop_stb) begin
      run_d  = 1'b0;
      half_d = 1'b0;
      lr_d   = 1'b0;
      div_d  = '0;
    end else if (run_q) begin
      if (div_hit) begin
        div_d  = '0;
        half_d = !half_q;
        if (half_q) begin
          bit_d = next_bit;
          lr_d  = ws_level(next_bit);
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      div_q  <= '0;
      lim_q  <= '0;
      bit_q  <= '0;
      lr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      half_q <= half_d;
      div_q  <= div_d;
      lim_q  <= lim_d;
      bit_q  <= bit_d;
      lr_q   <= lr_d;
      err_q  <= err_d;
    end
  end

  assign active  = run_q;
  assign cfg_err = err_q;
  assign bclk    = half_q;
  assign lrclk   = lr_q;
  assign bit_idx = bit_q;

endmodule

// File: rtl/i2sm_tx.sv
module i2sm_tx
  import i2sm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic              stop_stb,
  input  logic              fall_stb,
  input  logic [BIT_W-1:0]  next_bit,
  input  logic [SLOT_W-1:0] tx_left,
  input  logic [SLOT_W-1:0] tx_right,
  input  logic              tx_underflow,
  output logic              frame_take,
  output logic              sdout
);

  localparam int SH_W = FRAME_BITS - 1;

  stereo_word_t     hold_q, hold_d;
  logic [SH_W-1:0]  sh_q,   sh_d;
  logic             sd_q,   sd_d;
  logic             take_q, take_d;
  logic             hold_en;

  assign hold_en = take_q;

  always_comb begin
    take_d = fall_stb && (next_bit == BIT_W'(FRAME_BITS - 1));
    hold_d = hold_q;
    if (hold_en) begin
      if (tx_underflow) begin
        hold_d = '0;
      end else begin
        hold_d.left  = tx_left;
        hold_d.right = tx_right;
      end
    end
    sh_d = sh_q;
    sd_d = sd_q;
    if (start_stb || stop_stb) begin
      sh_d = '0;
      sd_d = 1'b0;
    end else if (fall_stb) begin
      if (next_bit == '0) begin
        sd_d = hold_q[FRAME_BITS-1];
        sh_d = hold_q[SH_W-1:0];
      end else begin
        sd_d = sh_q[SH_W-1];
        sh_d = {sh_q[SH_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      take_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      sd_q   <= sd_d;
      take_q <= take_d;
    end
  end

  assign frame_take = take_q;
  assign sdout      = sd_q;

endmodule

// File: rtl/i2sm_rx.sv
module i2sm_rx
  import i2sm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic              rise_stb,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              sdin,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_left,
  output logic [SLOT_W-1:0] rx_right
);

  logic [SLOT_W-2:0] sh_q,   sh_d;
  logic [SLOT_W-1:0] lft_q,  lft_d;
  logic              have_q, have_d;
  logic              vld_q,  vld_d;
  stereo_word_t      out_q,  out_d;
  logic [SLOT_W-1:0] word;

  assign word = {sh_q, sdin};

  always_comb begin
    sh_d   = sh_q;
    lft_d  = lft_q;
    have_d = have_q;
    vld_d  = 1'b0;
    out_d  = out_q;
    if (start_stb) begin
      have_d = 1'b0;
    end else if (rise_stb) begin
      sh_d = word[SLOT_W-2:0];
      if (bit_idx == BIT_W'(SLOT_W - 1)) begin
        lft_d  = word;
        have_d = 1'b1;
      end
      if ((bit_idx == BIT_W'(FRAME_BITS - 1)) && have_q) begin
        vld_d       = 1'b1;
        out_d.left  = lft_q;
        out_d.right = word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lft_q  <= '0;
      have_q <= 1'b0;
      vld_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      lft_q  <= lft_d;
      have_q <= have_d;
      vld_q  <= vld_d;
      out_q  <= out_d;
    end
  end

  assign rx_valid = vld_q;
  assign rx_left  = out_q.left;
  assign rx_right = out_q.right;

endmodule

// File: rtl/i2s_master_port.sv
module i2s_master_port
  import i2sm_pkg::*;
#(
  parameter int RATIO_LOG2_MAX = 4,
  parameter int CODE_W         = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              cfg_err,
  output logic              active,
  input  logic [SLOT_W-1:0] tx_left,
  input  logic [SLOT_W-1:0] tx_right,
  input  logic              tx_underflow,
  output logic              frame_take,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_left,
  output logic [SLOT_W-1:0] rx_right,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdout,
  input  logic              sdin
);

  logic [BIT_W-1:0] bit_idx;
  logic [BIT_W-1:0] next_bit;
  logic             start_stb;
  logic             stop_stb;
  logic             fall_stb;
  logic             rise_stb;

  i2sm_clkgen #(
    .RATIO_LOG2_MAX (RATIO_LOG2_MAX),
    .CODE_W         (CODE_W)
  ) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .ratio_code (ratio_code),
    .active     (active),
    .cfg_err    (cfg_err),
    .bclk       (bclk),
    .lrclk      (lrclk),
    .bit_idx    (bit_idx),
    .next_bit   (next_bit),
    .start_stb  (start_stb),
    .stop_stb   (stop_stb),
    .fall_stb   (fall_stb),
    .rise_stb   (rise_stb)
  );

  i2sm_tx u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_stb    (start_stb),
    .stop_stb     (stop_stb),
    .fall_stb     (fall_stb),
    .next_bit     (next_bit),
    .tx_left      (tx_left),
    .tx_right     (tx_right),
    .tx_underflow (tx_underflow),
    .frame_take   (frame_take),
    .sdout        (sdout)
  );

  i2sm_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_stb (start_stb),
    .rise_stb  (rise_stb),
    .bit_idx   (bit_idx),
    .sdin      (sdin),
    .rx_valid  (rx_valid),
    .rx_left   (rx_left),
    .rx_right  (rx_right)
  );

endmodule

// File: rtl/i2sm_checker.sv
module i2sm_checker #(
  parameter int RATIO_LOG2_MAX = 4
) (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic stop_req,
  input logic bclk,
  input logic lrclk,
  input logic sdout,
  input logic frame_take,
  input logic rx_valid,
  input logic cfg_err
);

  localparam int CNT_W    = RATIO_LOG2_MAX + 2;
  localparam int MAX_HALF = 1 << RATIO_LOG2_MAX;

  logic [CNT_W-1:0] lvl_cnt;
  logic             bclk_prev;

  // Cycles spent at the present bclk level, minus one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_cnt   <= '0;
      bclk_prev <= 1'b0;
    end else begin
      bclk_prev <= bclk;
      if (!active || (bclk != bclk_prev)) lvl_cnt <= '0;
      else                                lvl_cnt <= lvl_cnt + CNT_W'(1);
    end
  end

  a_r1_half_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (lvl_cnt < CNT_W'(MAX_HALF)));

  a_r2_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !active);

  a_r3_ws_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(lrclk)) |-> $fell(bclk));

  a_r4_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(sdout)) |-> $fell(bclk));

  a_r6_stop_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop_req) |=> (!active && !bclk && !lrclk && !sdout));

  a_r7_take_in_left_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |-> (active && !lrclk && !bclk));

  a_r7_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |=> !frame_take);

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind i2s_master_port i2sm_checker #(
  .RATIO_LOG2_MAX (RATIO_LOG2_MAX)
) u_i2sm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .stop_req   (stop_req),
  .bclk       (bclk),
  .lrclk      (lrclk),
  .sdout      (sdout),
  .frame_take (frame_take),
  .rx_valid   (rx_valid),
  .cfg_err    (cfg_err)
);

// File: tb/tb_i2s_master_port.sv
`timescale 1ns/1ps
module tb_i2s_master_port;

  logic        clk;
  logic        rst_n;
  logic        start_req;
  logic        stop_req;
  logic [2:0]  ratio_code;
  logic        cfg_err;
  logic        active;
  logic [31:0] tx_left;
  logic [31:0] tx_right;
  logic        tx_underflow;
  logic        frame_take;
  logic        rx_valid;
  logic [31:0] rx_left;
  logic [31:0] rx_right;
  logic        bclk;
  logic        lrclk;
  logic        sdout;
  logic        sdin;

  i2s_master_port dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .ratio_code(ratio_code), .cfg_err(cfg_err), .active(active),
    .tx_left(tx_left), .tx_right(tx_right), .tx_underflow(tx_underflow),
    .frame_take(frame_take), .rx_valid(rx_valid), .rx_left(rx_left),
    .rx_right(rx_right), .bclk(bclk), .lrclk(lrclk), .sdout(sdout), .sdin(sdin)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] rx_word(input int fn);
    return {32'h80000001 ^ (fn * 32'h01234567), 32'h7FFE0003 + fn * 32'h00F0F0F1};
  endfunction

  function automatic logic [63:0] tx_word(input int k);
    return {32'hA5A50000 + k * 32'h00013579, 32'h5A5A0000 ^ (k * 32'h80024681)};
  endfunction

  // Reference model state
  bit          m_run = 1'b0;
  bit          m_err = 1'b0;
  int          m_h   = 1;
  int          m_p   = 0;
  logic [63:0] cap [0:31];
  bit          uf   [0:31];
  int          tx_seq  = 0;
  bit          tx_chg  = 1'b0;

  always @(negedge clk) begin
    int          half, bitn, fn, pos;
    logic        e_bclk, e_lr, e_sd, e_take, e_rxv;
    logic [63:0] e_rx;
    string       sd_tag, ck_tag;
    if (tx_chg) begin
      tx_seq++;
      {tx_left, tx_right} = tx_word(tx_seq);
      tx_chg = 1'b0;
    end
    e_bclk = 0; e_lr = 0; e_sd = 0; e_take = 0; e_rxv = 0; e_rx = '0;
    fn = 0; bitn = 0; sd_tag = "R4"; ck_tag = "R1";
    if (m_run) begin
      half   = (m_p / m_h) % 2;
      bitn   = (m_p / (2 * m_h)) % 64;
      fn     = m_p / (128 * m_h);
      pos    = m_p % (128 * m_h);
      e_bclk = half[0];
      e_lr   = (bitn >= 31) && (bitn <= 62);
      e_sd   = cap[fn][63 - bitn];
      e_take = (pos == 126 * m_h);
      e_rxv  = (pos == 127 * m_h) && (fn >= 1);
      e_rx   = rx_word(fn);
      if (uf[fn]) sd_tag = "R8";
      if (m_p < 126 * m_h) ck_tag = "R5";
    end
    chk({ck_tag, " bclk"}, bclk, e_bclk);
    chk("R3 lrclk", lrclk, e_lr);
    chk({sd_tag, " sdout"}, sdout, e_sd);
    chk("R6 active", active, m_run);
    chk("R2 cfg_err", cfg_err, m_err);
    chk("R7 frame_take", frame_take, e_take);
    chk("R9 rx_valid", rx_valid, e_rxv);
    if (e_rxv) chk("R9 rx pair", {rx_left, rx_right}, e_rx);
    // serial ADC data for the current bit, sampled at the next rising edge
    sdin = m_run ? e_rx[63 - bitn] : 1'b0;
    // advance to the state after the coming clock edge
    if (!rst_n) begin
      m_run = 0; m_err = 0;
    end else if (m_run && stop_req) begin
      m_run = 0;
    end else if (m_run) begin
      if (e_take) begin
        cap[fn + 1] = tx_underflow ? 64'd0 : {tx_left, tx_right};
        uf[fn + 1]  = tx_underflow;
        tx_chg      = 1'b1;
      end
      m_p++;
    end else if (start_req) begin
      if (ratio_code <= 3'd4) begin
        m_run = 1; m_err = 0;
        m_h   = 1 << ratio_code;
        m_p   = 125 * m_h;
        for (int i = 0; i < 32; i++) begin cap[i] = '0; uf[i] = 0; end
      end else begin
        m_err = 1;
      end
    end
  end

  task automatic pulse_start(input logic [2:0] code);
    @(posedge clk); #2 ratio_code = code; start_req = 1'b1;
    @(posedge clk); #2 start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(posedge clk); #2 stop_req = 1'b1;
    @(posedge clk); #2 stop_req = 1'b0;
  endtask

  task automatic run_frames(input logic [2:0] code, input int frames);
    pulse_start(code);
    repeat (frames * 128 * (1 << code)) @(posedge clk);
    pulse_stop();
    repeat (5) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_req = 1'b0; stop_req = 1'b0; ratio_code = 3'd0;
    tx_underflow = 1'b0; sdin = 1'b0;
    {tx_left, tx_right} = tx_word(0);
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // reset state: idle, everything low (R6)
    chk("R6 reset bclk", bclk, 0);
    chk("R6 reset lrclk", lrclk, 0);
    chk("R6 reset sdout", sdout, 0);
    chk("R6 reset active", active, 0);
    // every legal ratio (R1, R3, R4, R5, R7, R9)
    run_frames(3'd0, 4);
    run_frames(3'd1, 3);
    run_frames(3'd2, 3);
    run_frames(3'd4, 3);
    // underflow held across two captures (R8)
    pulse_start(3'd3);
    repeat (128 * 8 + 300) @(posedge clk);
    #2 tx_underflow = 1'b1;
    repeat (128 * 8 * 2) @(posedge clk);
    #2 tx_underflow = 1'b0;
    repeat (128 * 8 * 2) @(posedge clk);
    pulse_stop();
    repeat (5) @(posedge clk);
    // refused ratio codes (R2)
    pulse_start(3'd5);
    repeat (20) @(posedge clk);
    pulse_start(3'd7);
    repeat (20) @(posedge clk);
    // a valid start clears the error; stop mid-bit and restart at once (R6)
    pulse_start(3'd2);
    repeat (700) @(posedge clk);
    pulse_stop();
    pulse_start(3'd1);
    repeat (128 * 2 * 2 + 50) @(posedge clk);
    pulse_stop();
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R6 final idle", {active, bclk, lrclk, sdout}, 4'b0000);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule